// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five software localities, numbered 0 to 4, owns a shared security-module register interface at any moment. Each locality reaches the arbiter through its own 4 KB address window, chosen by address bits [14:12]. At offset 0 of its window it finds an access register. Through that register a locality asks for the interface, checks whether it holds it, sees whether some other locality is queued behind it, and gives the interface up.

The arbiter is a two-state machine. In `ST_FREE` nobody owns the interface. In `ST_HELD` exactly one locality, held in an owner register, owns it. The transition `FREE->HELD` (grant) fires on the first clock edge on which any request is pending, and it picks the highest-numbered requester. The transition `HELD->FREE` (release) fires when the owner writes its active bit. `FREE->FREE` (stay idle) and `HELD->HELD` (keep ownership) cover every other cycle.

After a release, the next waiting request is granted on the following edge. Every transition between the two states raises a one-cycle event for the interrupt logic. A one-hot output reports the current owner to the rest of the module.

Top module: `loc_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, no locality is active, no request is pending and `loc_change` is 0.
- R2: Outside reset, a read of offset 0 in any window 0..NUM_LOC-1 returns bit 7 (valid) set to 1.
- R3: A write with bit 1 set to offset 0 of a locality's window records a request for that locality. Reading that register then shows bit 1 set until the request is granted.
- R4: When no locality is active and at least one request is pending, the highest-numbered pending locality becomes active on the next clock edge.
- R5: A grant clears the granted locality's own request, so its bit 1 reads 0 once it is active.
- R6: When the active locality writes its access register with bit 5 set, no locality is active from the next edge on.
- R7: A write of bit 5 by a locality that is not active has no effect on ownership.
- R8: Bit 5 reads 1 only in the active locality's register. Bit 2 reads 1 only in the active locality's register, and only while a different locality has a request outstanding.
- R9: `loc_change` is 1 for exactly one cycle after each edge on which `active_loc` changes, and 0 otherwise.
- R10: `active_loc` never has more than one bit set.
- R11: Writes to windows NUM_LOC..7, or to any nonzero offset, change nothing. Reads from those addresses return 0.
- R12: A request written by the locality that is already active is ignored. After that locality releases, no locality is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 15 | Address: bits [14:12] pick the locality window, bits [11:0] the offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read of the addressed access register |
| active_loc | output | 5 | One-hot owner of the interface, all zero when free |
| loc_change | output | 1 | One-cycle pulse after each ownership change |

## Verification
The bench builds the arbiter with its default parameters: five localities, a 3-bit window select and a 12-bit offset. Because five localities do not fill the 3-bit select, windows 5, 6 and 7 are real addresses that must be ignored, and the bench probes them. With five request lines, the bench can queue several requesters behind an owner. This lets it check the priority order, the pending-flag view from the owner's side, and the release-then-regrant sequence.

// File: rtl/lar_pkg.sv
package lar_pkg;
    typedef enum logic [0:0] {
        ST_FREE = 1'b0,
        ST_HELD = 1'b1
    } arb_state_t;

    localparam int BIT_VALID  = 7;
    localparam int BIT_ACTIVE = 5;
    localparam int BIT_OTHERS = 2;
    localparam int BIT_REQ    = 1;
endpackage

// File: rtl/lar_req_bank.sv
module lar_req_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            // a clear (grant) outranks a set in the same cycle
            pend_q <= (pend_q | set_vec) & ~clr_vec;
        end
    end
endmodule

// File: rtl/lar_high_pick.sv
module lar_high_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        // later iterations overwrite earlier ones: highest index wins
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/lar_read_view.sv
module lar_read_view #(
    parameter int N    = 5,
    parameter int SELW = 3,
    parameter int DW   = 8
) (
    input  logic            valid,
    input  logic [SELW-1:0] sel,
    input  logic            off_zero,
    input  logic [N-1:0]    active_vec,
    input  logic [N-1:0]    pend_vec,
    output logic [DW-1:0]   rdata
);
    import lar_pkg::*;

    logic [N-1:0] others_waiting;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_oth
            assign others_waiting[g] = |(pend_vec & ~(N'(1) << g));
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (off_zero && int'(sel) == i) begin
                rdata[BIT_VALID]  = valid;
                rdata[BIT_ACTIVE] = active_vec[i];
                rdata[BIT_OTHERS] = active_vec[i] & others_waiting[i];
                rdata[BIT_REQ]    = pend_vec[i];
            end
        end
    end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter #(
    parameter int NUM_LOC = 5,
    parameter int SEL_W   = 3,
    parameter int OFF_W   = 12,
    parameter int DATA_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic [SEL_W+OFF_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_LOC-1:0]       active_loc,
    output logic                     loc_change
);
    import lar_pkg::*;

    localparam int ADDR_W = SEL_W + OFF_W;
    localparam int IDX_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;

    arb_state_t         state_q, state_d;
    logic [IDX_W-1:0]   owner_q, owner_d;
    logic               change_q;
    logic [NUM_LOC-1:0] pend_q, set_vec, clr_vec;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;

    logic [SEL_W-1:0]   acc_sel;
    logic               off_zero, win_ok, acc_hit;
    logic               by_owner, rel_hit;

    assign acc_sel  = bus_addr[ADDR_W-1:OFF_W];
    assign off_zero = (bus_addr[OFF_W-1:0] == '0);
    assign win_ok   = (int'(acc_sel) < NUM_LOC);
    assign acc_hit  = bus_we && off_zero && win_ok;
    assign by_owner = (state_q == ST_HELD) && (int'(acc_sel) == int'(owner_q));
    assign rel_hit  = acc_hit && by_owner && bus_wdata[BIT_ACTIVE];

    genvar g;
    generate
        for (g = 0; g < NUM_LOC; g++) begin : g_set
            assign set_vec[g] = acc_hit && bus_wdata[BIT_REQ] && !by_owner
                                && (int'(acc_sel) == g);
            assign clr_vec[g] = (state_q == ST_FREE) && pick_any
                                && (int'(pick_idx) == g);
        end
    endgenerate

    lar_req_bank #(.N(NUM_LOC)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend_q  (pend_q)
    );

    lar_high_pick #(.N(NUM_LOC), .IW(IDX_W)) u_pick (
        .req (pend_q),
        .any (pick_any),
        .idx (pick_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_FREE;
            owner_q  <= '0;
            change_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            owner_q  <= owner_d;
            change_q <= (state_d != state_q);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ST_FREE: begin
                if (pick_any) begin
                    state_d = ST_HELD;
                    owner_d = pick_idx;
                end
            end
            ST_HELD: begin
                if (rel_hit) state_d = ST_FREE;
            end
        endcase
    end

    // outputs
    always_comb begin
        active_loc = '0;
        if (state_q == ST_HELD) active_loc = NUM_LOC'(1) << owner_q;
        loc_change = change_q;
    end

    lar_read_view #(.N(NUM_LOC), .SELW(SEL_W), .DW(DATA_W)) u_view (
        .valid      (!rst),
        .sel        (acc_sel),
        .off_zero   (off_zero),
        .active_vec (active_loc),
        .pend_vec   (pend_q),
        .rdata      (bus_rdata)
    );
endmodule

// File: rtl/loc_arbiter_chk.sv
module loc_arbiter_chk #(
    parameter int NUM_LOC = 5,
    parameter int SEL_W   = 3,
    parameter int OFF_W   = 12,
    parameter int DATA_W  = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_we,
    input logic [SEL_W+OFF_W-1:0] bus_addr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [NUM_LOC-1:0]     active_loc,
    input logic                   loc_change,
    input logic [NUM_LOC-1:0]     pend_q
);
    logic [SEL_W-1:0] sel;
    logic             at_acc, outside, owner_rel;

    always_comb begin
        sel       = bus_addr[SEL_W+OFF_W-1:OFF_W];
        at_acc    = (bus_addr[OFF_W-1:0] == '0) && (int'(sel) < NUM_LOC);
        outside   = !at_acc;
        owner_rel = 1'b0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (bus_we && at_acc && int'(sel) == i && active_loc[i] && bus_wdata[5])
                owner_rel = 1'b1;
        end
    end

    a_r10_one_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active_loc));

    a_r9_change_pulse: assert property (@(posedge clk) disable iff (rst)
        loc_change == (active_loc != $past(active_loc)));

    a_r4_grant_next: assert property (@(posedge clk) disable iff (rst)
        (active_loc == '0 && pend_q != '0) |=> (active_loc != '0));

    a_r5_grant_clears: assert property (@(posedge clk) disable iff (rst)
        (active_loc == '0 && pend_q != '0) |=> ((pend_q & active_loc) == '0));

    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        owner_rel |=> (active_loc == '0));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (active_loc != '0 && !owner_rel) |=> $stable(active_loc));

    a_r2_valid: assert property (@(posedge clk) disable iff (rst)
        at_acc |-> bus_rdata[7]);

    a_r11_outside_zero: assert property (@(posedge clk) disable iff (rst)
        outside |-> (bus_rdata == '0));
endmodule

bind loc_arbiter loc_arbiter_chk #(
    .NUM_LOC (NUM_LOC),
    .SEL_W   (SEL_W),
    .OFF_W   (OFF_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .active_loc (active_loc),
    .loc_change (loc_change),
    .pend_q     (pend_q)
);

// File: tb/sim_loc_arbiter.sv
module sim_loc_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [4:0]  act;
    logic        chg;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    loc_arbiter u0 (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (we),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .active_loc (act),
        .loc_change (chg)
    );

    task automatic do_write(input int loc, input int off, input logic [7:0] d);
        @(negedge clk);
        we    = 1'b1;
        addr  = {3'(loc), 12'(off)};
        wdata = d;
        @(negedge clk);
        we    = 1'b0;
        wdata = '0;
    endtask

    task automatic expect_rd(input int loc, input int off, input logic [7:0] exp,
                             input string tag);
        addr = {3'(loc), 12'(off)};
        #1;
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s read loc %0d off %0d: actual %h expected %h",
                     tag, loc, off, rdata, exp);
        end
    endtask

    task automatic expect_act(input logic [4:0] exp_a, input logic exp_c,
                              input string tag);
        checks++;
        if (act !== exp_a || chg !== exp_c) begin
            fails++;
            $display("FAIL %s active/change: actual %b/%b expected %b/%b",
                     tag, act, chg, exp_a, exp_c);
        end
    endtask

    task automatic t_reset();
        expect_act(5'b0, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;
        expect_act(5'b0, 1'b0, "R1");
        expect_rd(0, 0, 8'h80, "R2");
        expect_rd(4, 0, 8'h80, "R2");
    endtask

    task automatic t_single_grant();
        do_write(2, 0, 8'h02);
        expect_rd(2, 0, 8'h82, "R3");
        expect_act(5'b0, 1'b0, "R3");
        @(negedge clk);
        expect_act(5'b00100, 1'b1, "R4");
        expect_rd(2, 0, 8'hA0, "R5");
        @(negedge clk);
        expect_act(5'b00100, 1'b0, "R9");
    endtask

    task automatic t_priority_handoff();
        do_write(0, 0, 8'h02);
        do_write(3, 0, 8'h02);
        expect_rd(2, 0, 8'hA4, "R8");
        expect_rd(3, 0, 8'h82, "R8");
        expect_rd(1, 0, 8'h80, "R8");
        do_write(3, 0, 8'h20);
        expect_act(5'b00100, 1'b0, "R7");
        do_write(2, 0, 8'h20);
        expect_act(5'b0, 1'b1, "R6");
        @(negedge clk);
        expect_act(5'b01000, 1'b1, "R4");
        expect_rd(3, 0, 8'hA4, "R8");
        expect_rd(0, 0, 8'h82, "R3");
        do_write(3, 0, 8'h20);
        expect_act(5'b0, 1'b1, "R6");
        @(negedge clk);
        expect_act(5'b00001, 1'b1, "R4");
        expect_rd(0, 0, 8'hA0, "R8");
    endtask

    task automatic t_owner_request();
        do_write(0, 0, 8'h02);
        expect_rd(0, 0, 8'hA0, "R12");
        do_write(0, 0, 8'h20);
        expect_act(5'b0, 1'b1, "R6");
        @(negedge clk);
        expect_act(5'b0, 1'b0, "R12");
    endtask

    task automatic t_outside();
        do_write(5, 0, 8'h02);
        do_write(7, 0, 8'h02);
        do_write(1, 4, 8'h02);
        @(negedge clk);
        expect_act(5'b0, 1'b0, "R11");
        expect_rd(1, 0, 8'h80, "R11");
        expect_rd(6, 0, 8'h00, "R11");
        expect_rd(1, 4, 8'h00, "R11");
    endtask

    task automatic t_reset_mid();
        do_write(4, 0, 8'h02);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        expect_act(5'b0, 1'b0, "R1");
        rst = 1'b0;
        expect_act(5'b0, 1'b0, "R1");
        expect_rd(4, 0, 8'h80, "R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_single_grant();
        t_priority_handoff();
        t_owner_request();
        t_outside();
        t_reset_mid();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #80000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule